// File: doc/BRIEF.md
# Paged Byte-Store Access Controller

This block places a small register file in front of a page-organised byte store, so that a host can move whole pages between its bus and the store. The host sees four byte-wide registers on a two-bit address: a write-mode guard, a command/status register, a page selector and a data port that leads into a 32-byte FIFO. A page is always handled as a unit. To write one, the host fills the FIFO through the data port and then issues a program command. To read one, the host issues a load command and then drains the FIFO.

The store holds 232 pages of 32 bytes and sits inside the block. Programming takes a configurable number of cycles for each byte, which models a slow nonvolatile array. Loading takes one cycle per byte. A ready flag stays low for the whole of each transfer. A sticky error flag records commands that were refused.

Register map, by address: 0 = write mode (writes are enabled only when it holds 0x01), 1 = command/status, 2 = page number, 3 = data port. Status reads back as bit 7 = ready and bit 6 = error, with the other bits 0. Command codes: 0x00 clears the FIFO, 0x01 programs the selected page from the FIFO, 0x02 loads the selected page into the FIFO. Byte i of a page is the i-th byte pushed or popped.

Top module: `pgstore_ctrl`

## Requirements
- R1: After reset, the write-mode and page registers read 0x00, status reads 0x80 (ready=1, error=0), and a read of the data port returns 0x00 (the FIFO is empty).
- R2: A program command (0x01), accepted with write mode 0x01 and a page of 231 or less, stores the 32 FIFO bytes into that page in push order. A later load command (0x02) followed by 32 data-port reads returns them in the same order. Write mode may stay 0x01 across several program commands.
- R3: The FIFO holds at most 32 bytes, and a 33rd push is dropped. A data-port read of an empty FIFO returns 0x00.
- R4: Command 0x00 empties the FIFO.
- R5: A program command while write mode is not 0x01 is refused. Ready stays 1, status bit 6 is set, and the page is unchanged.
- R6: A program or load command with a page number above 231 (0xE7) is refused and sets status bit 6.
- R7: Any command written while ready is 1 clears the error bit, unless that command is itself refused.
- R8: Commands written while ready is 0 are ignored, and so are data-port accesses.
- R9: Ready stays 0 for exactly 32×WR_CYC cycles after a program command and for exactly 32 cycles after a load command, counted from the clock edge that accepts the command.
- R10: A load command discards any bytes left in the FIFO before it fills the FIFO from the page.
- R11: A program command pops the FIFO once per byte. Bytes missing from a partly filled FIFO are stored as 0x00, and the FIFO is empty afterwards.
- R12: The page contents survive assertion of rst_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (store contents kept) |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; pops the FIFO when address is 3 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |

## Verification
Pages are programmed with an incrementing ramp, with an alternating 0x55/0xAA pattern XORed with the index, and with all 0xFF, at pages 0, 100 and 231. Swapped, repeated or stuck byte lanes and wrong page decoding therefore show up as mismatches. A 4-byte partial fill separates zero padding from stale FIFO data. A 5-byte partial drain followed by a load of a different page separates a proper discard from leftover bytes. Refused commands are checked against a page with known contents, so a refused write that still reached the store is caught. The length of the busy window is counted edge by edge for both directions, which exposes an off-by-one in the per-byte wait.

// File: rtl/pgstore_pkg.sv
package pgstore_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_PROG,
    S_LOAD
  } seq_state_t;

  localparam logic [7:0] CMD_CLEAR = 8'h00;
  localparam logic [7:0] CMD_PROG  = 8'h01;
  localparam logic [7:0] CMD_LOAD  = 8'h02;
  localparam logic [7:0] WMODE_ON  = 8'h01;

  // page number inside the store
  function automatic logic page_ok(input logic [7:0] p, input int unsigned pages);
    return 32'(p) < pages;
  endfunction

  // cycles ready is low during a program transfer
  function automatic int unsigned prog_cycles(input int unsigned bytes, input int unsigned per);
    return bytes * per;
  endfunction

endpackage

// File: rtl/pgstore_fifo.sv
module pgstore_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);

  logic [W-1:0]  slot [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign dout    = (count == '0) ? '0 : slot[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) slot[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/pgstore_array.sv
module pgstore_array #(
  parameter int PAGES      = 232,
  parameter int PAGE_BYTES = 32,
  localparam int PW        = $clog2(PAGES),
  localparam int IW        = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] page,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    wbyte,
  output logic [7:0]    rbyte
);

  // one wide word per page keeps the element count at PAGES
  logic [PAGE_BYTES*8-1:0] mem [PAGES];

  always_ff @(posedge clk) begin
    if (we) mem[page][{idx, 3'b000} +: 8] <= wbyte;
  end

  assign rbyte = (32'(page) < PAGES) ? mem[page][{idx, 3'b000} +: 8] : 8'h00;

endmodule

// File: rtl/pgstore_seq.sv
module pgstore_seq
  import pgstore_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYC     = 4,
  parameter int PW         = 8,
  localparam int IW        = $clog2(PAGE_BYTES),
  localparam int WCW       = (WR_CYC > 1) ? $clog2(WR_CYC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_wr,
  input  logic          start_rd,
  input  logic [PW-1:0] page_in,
  output logic          busy,
  output logic [PW-1:0] cur_page,
  output logic [IW-1:0] idx,
  output logic          seq_pop,
  output logic          seq_push,
  output logic          arr_we
);

  seq_state_t     state;
  logic [WCW-1:0] wcnt;
  logic           tick, last;

  assign tick     = (wcnt == WCW'(WR_CYC - 1));
  assign last     = (idx == IW'(PAGE_BYTES - 1));
  assign busy     = (state != S_IDLE);
  assign arr_we   = (state == S_PROG) && tick;
  assign seq_pop  = arr_we;
  assign seq_push = (state == S_LOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      wcnt     <= '0;
      cur_page <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          idx  <= '0;
          wcnt <= '0;
          if (start_wr) begin
            state    <= S_PROG;
            cur_page <= page_in;
          end else if (start_rd) begin
            state    <= S_LOAD;
            cur_page <= page_in;
          end
        end
        S_PROG: begin
          if (tick) begin
            wcnt <= '0;
            if (last) state <= S_IDLE;
            else      idx   <= idx + 1'b1;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_LOAD: begin
          if (last) state <= S_IDLE;
          else      idx   <= idx + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pgstore_ctrl.sv
module pgstore_ctrl
  import pgstore_pkg::*;
#(
  parameter int PAGES      = 232,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYC     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);

  localparam int PW = $clog2(PAGES);
  localparam int IW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(PAGE_BYTES + 1);

  logic [7:0]    wmode_q, page_q;
  logic          err_q;
  logic          ready, busy;
  logic          sel_cmd, sel_push, sel_pop;
  logic          cmd_ok, wen, pg_ok;
  logic          start_wr, start_rd, cmd_bad, fifo_clr;
  logic          host_push, host_pop, seq_push, seq_pop, arr_we;
  logic [PW-1:0] cur_page;
  logic [IW-1:0] idx;
  logic [7:0]    arr_byte, fifo_dout;
  logic [CW-1:0] fifo_cnt;

  assign ready    = !busy;
  assign sel_cmd  = bus_wr && (bus_addr == 2'd1);
  assign sel_push = bus_wr && (bus_addr == 2'd3);
  assign sel_pop  = bus_rd && (bus_addr == 2'd3);
  assign cmd_ok   = sel_cmd && ready;
  assign wen      = (wmode_q == WMODE_ON);
  assign pg_ok    = page_ok(page_q, PAGES);

  assign start_wr = cmd_ok && (bus_wdata == CMD_PROG) && wen && pg_ok;
  assign start_rd = cmd_ok && (bus_wdata == CMD_LOAD) && pg_ok;
  assign cmd_bad  = cmd_ok && (((bus_wdata == CMD_PROG) && !(wen && pg_ok)) ||
                               ((bus_wdata == CMD_LOAD) && !pg_ok));
  assign fifo_clr = cmd_ok && ((bus_wdata == CMD_CLEAR) || start_rd);

  assign host_push = sel_push && ready;
  assign host_pop  = sel_pop && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wmode_q <= '0;
      page_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == 2'd0) wmode_q <= bus_wdata;
      if (bus_wr && bus_addr == 2'd2) page_q  <= bus_wdata;
      if (cmd_ok)                     err_q   <= cmd_bad;
    end
  end

  always_comb begin
    unique case (bus_addr)
      2'd0:    bus_rdata = wmode_q;
      2'd1:    bus_rdata = {ready, err_q, 6'b0};
      2'd2:    bus_rdata = page_q;
      default: bus_rdata = fifo_dout;
    endcase
  end

  pgstore_fifo #(.DEPTH(PAGE_BYTES), .W(8)) fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .push  (host_push || seq_push),
    .pop   (host_pop || seq_pop),
    .din   (seq_push ? arr_byte : bus_wdata),
    .dout  (fifo_dout),
    .count (fifo_cnt)
  );

  pgstore_seq #(.PAGE_BYTES(PAGE_BYTES), .WR_CYC(WR_CYC), .PW(PW)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_wr (start_wr),
    .start_rd (start_rd),
    .page_in  (page_q[PW-1:0]),
    .busy     (busy),
    .cur_page (cur_page),
    .idx      (idx),
    .seq_pop  (seq_pop),
    .seq_push (seq_push),
    .arr_we   (arr_we)
  );

  pgstore_array #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) array_i (
    .clk   (clk),
    .we    (arr_we),
    .page  (cur_page),
    .idx   (idx),
    .wbyte (fifo_dout),
    .rbyte (arr_byte)
  );

endmodule

// File: rtl/pgstore_ctrl_chk.sv
module pgstore_ctrl_chk
  import pgstore_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYC     = 4,
  localparam int CW        = $clog2(PAGE_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          err,
  input logic          cmd_strobe,
  input logic          push_try,
  input logic          arr_we,
  input logic [CW-1:0] fifo_cnt
);

  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n || ready) busy_run <= 0;
    else                 busy_run <= busy_run + 1;
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(PAGE_BYTES));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready && push_try && fifo_cnt == CW'(PAGE_BYTES) |=> fifo_cnt == CW'(PAGE_BYTES));

  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(cmd_strobe) && $past(ready));

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(cmd_strobe));

  p_store_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !ready);

  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> busy_run < prog_cycles(PAGE_BYTES, WR_CYC));

endmodule

bind pgstore_ctrl pgstore_ctrl_chk #(.PAGE_BYTES(PAGE_BYTES), .WR_CYC(WR_CYC)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (ready),
  .err        (err_q),
  .cmd_strobe (sel_cmd),
  .push_try   (sel_push),
  .arr_we     (arr_we),
  .fifo_cnt   (fifo_cnt)
);

// File: tb/pgstore_ctrl_tb.sv
`timescale 1ns/1ps
module pgstore_ctrl_tb_top;

  localparam int WRC = 3;
  localparam int PB  = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pgstore_ctrl #(.PAGES(232), .PAGE_BYTES(PB), .WR_CYC(WRC)) dut_i (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata
  );

  function automatic logic [7:0] pat(input int kind, input int i);
    case (kind)
      0:       return 8'(i + 1);
      1:       return ((i % 2) ? 8'hAA : 8'h55) ^ 8'(i);
      default: return 8'hFF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // counts negedges with ready low, starting right after the command
  task automatic wait_ready(output int n);
    n = 0;
    bus_addr = 2'd1;
    #1;
    while (!bus_rdata[7] && n < 10000) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic fill_fifo(input int kind, input int cnt);
    bwr(2'd1, 8'h00);
    for (int i = 0; i < cnt; i++) bwr(2'd3, pat(kind, i));
  endtask

  task automatic program_page(input int page, input int kind);
    int n;
    fill_fifo(kind, PB);
    bwr(2'd2, 8'(page));
    bwr(2'd1, 8'h01);
    wait_ready(n);
  endtask

  task automatic load_page(input int page);
    int n;
    bwr(2'd2, 8'(page));
    bwr(2'd1, 8'h02);
    wait_ready(n);
  endtask

  task automatic drain_cmp(input string req, input int kind);
    logic [7:0] d;
    int bad = 0;
    for (int i = 0; i < PB; i++) begin
      brd(2'd3, d);
      if (d !== pat(kind, i)) bad++;
    end
    chk_int(req, bad, 0);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    brd(2'd0, d); chk("R1 write mode", d, 8'h00);
    brd(2'd2, d); chk("R1 page", d, 8'h00);
    brd(2'd1, d); chk("R1 status", d, 8'h80);
    brd(2'd3, d); chk("R1 empty port", d, 8'h00);
  endtask

  task automatic t_roundtrip;
    bwr(2'd0, 8'h01);
    program_page(0, 0);
    program_page(231, 1);
    program_page(100, 2);
    load_page(0);   drain_cmp("R2 page 0 ramp", 0);
    load_page(231); drain_cmp("R2 page 231 alt", 1);
    load_page(100); drain_cmp("R2 page 100 ones", 2);
  endtask

  task automatic t_fifo_limits;
    logic [7:0] d;
    fill_fifo(0, PB);
    bwr(2'd3, 8'hEE);
    drain_cmp("R3 33rd push dropped", 0);
    brd(2'd3, d); chk("R3 empty read", d, 8'h00);
    fill_fifo(1, 5);
    bwr(2'd1, 8'h00);
    brd(2'd3, d); chk("R4 clear empties", d, 8'h00);
  endtask

  task automatic t_guards;
    logic [7:0] d;
    int n;
    program_page(5, 1);
    bwr(2'd0, 8'h00);
    fill_fifo(2, PB);
    bwr(2'd2, 8'd5);
    bwr(2'd1, 8'h01);
    brd(2'd1, d); chk("R5 refused write status", d, 8'hC0);
    bwr(2'd1, 8'h00);
    brd(2'd1, d); chk("R7 error cleared", d, 8'h80);
    load_page(5); drain_cmp("R5 page unchanged", 1);
    bwr(2'd0, 8'h01);
    fill_fifo(2, PB);
    bwr(2'd2, 8'hE8);
    bwr(2'd1, 8'h01);
    brd(2'd1, d); chk("R6 write page 232", d, 8'hC0);
    bwr(2'd2, 8'hF0);
    bwr(2'd1, 8'h02);
    wait_ready(n);
    brd(2'd1, d); chk("R6 load page 240", d, 8'hC0);
    bwr(2'd2, 8'd5);
    bwr(2'd1, 8'h02);
    wait_ready(n);
    brd(2'd1, d); chk("R7 good load clears error", d, 8'h80);
    drain_cmp("R7 load data", 1);
  endtask

  task automatic t_busy;
    logic [7:0] d;
    int n;
    fill_fifo(0, PB);
    bwr(2'd2, 8'd9);
    bwr(2'd1, 8'h01);
    wait_ready(n);
    chk_int("R9 program busy cycles", n, PB * WRC);
    load_page(9);
    bwr(2'd1, 8'h00);
    bwr(2'd1, 8'h02);
    wait_ready(n);
    chk_int("R9 load busy cycles", n, PB);
    drain_cmp("R9 page 9 data", 0);
    fill_fifo(1, PB);
    bwr(2'd2, 8'd10);
    bwr(2'd1, 8'h01);
    bwr(2'd1, 8'h02);
    bwr(2'd1, 8'h00);
    bwr(2'd3, 8'h77);
    wait_ready(n);
    brd(2'd1, d); chk("R8 busy commands ignored status", d, 8'h80);
    brd(2'd3, d); chk("R8 FIFO empty after busy", d, 8'h00);
    load_page(10); drain_cmp("R8 page 10 intact", 1);
  endtask

  task automatic t_partial;
    logic [7:0] d;
    int n, bad;
    load_page(0);
    for (int i = 0; i < 5; i++) brd(2'd3, d);
    load_page(231); drain_cmp("R10 leftovers discarded", 1);
    fill_fifo(2, 4);
    bwr(2'd2, 8'd7);
    bwr(2'd1, 8'h01);
    wait_ready(n);
    brd(2'd3, d); chk("R11 FIFO empty after program", d, 8'h00);
    load_page(7);
    bad = 0;
    for (int i = 0; i < PB; i++) begin
      brd(2'd3, d);
      if (d !== ((i < 4) ? 8'hFF : 8'h00)) bad++;
    end
    chk_int("R11 padded page", bad, 0);
  endtask

  task automatic t_retain;
    logic [7:0] d;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    brd(2'd1, d); chk("R12 status after reset", d, 8'h80);
    load_page(0);   drain_cmp("R12 page 0 kept", 0);
    load_page(231); drain_cmp("R12 page 231 kept", 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_roundtrip();
    t_fifo_limits();
    t_guards();
    t_busy();
    t_partial();
    t_retain();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule